// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind the byte-level receiver of a serial memory slave. During a write transaction it takes a word address, then gathers the data bytes that follow into a small page latch. Each byte goes to the slot named by the low bits of a running pointer. Nothing is sent to the storage array while bytes are arriving.

When the bus STOP pulse arrives and at least one byte has been latched, the block starts a self-timed write interval. During this interval `busy` is high, so the surrounding slave can withhold acknowledges. The latched bytes go out through a plain write port to a register-based array, one per cycle in the first cycles of the interval. The length of the interval is a cycle-count parameter, so a testbench can use a short value and a real build can use one that matches the write time. The address width chooses between a 256-byte array (8 bits) and a 128-byte array (7 bits).

Top module: `pgwr_commit_top`

## Requirements
- R1: While reset is asserted and after it is released, `busy` is low and `mem_we` is low until a STOP commits latched data.
- R2: Each accepted data strobe stores its byte in the slot given by the low 3 pointer bits and then adds one to those bits, wrapping from 7 to 0. The upper address bits stay as loaded, so every write lands in the page that was addressed.
- R3: When more than 8 bytes arrive before STOP, a later byte replaces the earlier byte in the same slot. Only the last value per slot is written.
- R4: No array write occurs outside a busy interval. A STOP with at least one latched byte raises `busy` at the next clock edge, and `busy` stays high for exactly `WR_CYCLES` cycles.
- R5: In busy-interval cycle k (counting from 0), for k < 8, slot k is written to address {page, k} if that slot holds a latched byte.
- R6: Slots not written in the transaction produce no write, so those array locations keep their old contents.
- R7: A STOP with no byte latched, for example after an address alone, leaves `busy` low and writes nothing.
- R8: While `busy` is high, address loads and data strobes are ignored. They do not change what is committed, and they leave nothing latched afterwards.
- R9: Loading a word address discards every byte latched so far. Completing a commit also empties the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Strobe: take `addr_in` as the new word address |
| addr_in | input | ADDR_W | Word address |
| data_stb | input | 1 | Strobe: latch `data_in` at the pointer |
| data_in | input | 8 | Received data byte |
| stop_pulse | input | 1 | One-cycle STOP indication from the bus receiver |
| busy | output | 1 | Write interval in progress |
| mem_we | output | 1 | Array write enable |
| mem_waddr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The hardest case to reach from the ports is a page with gaps or overwritten slots. Bytes must be latched, cleared by a fresh address, wrapped past slot 7, and then committed. Separately, traffic must arrive while a commit is already running. The stimulus mixes directed cases of these kinds with random transactions of 0 to 11 bytes at random addresses, and some of the random transactions reload the address partway through. A bench-side model of the page and the array predicts each write and its cycle.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
  typedef logic [7:0] byte_t;
endpackage

// File: rtl/pgwr_ptr.sv
// Word-address pointer: fixed page base plus a wrapping in-page offset.
module pgwr_ptr #(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_en,
  input  logic [ADDR_W-1:0]   load_addr,
  input  logic                step_en,
  output logic [ADDR_W-OFF_W-1:0] base_q,
  output logic [OFF_W-1:0]    off_q
);
  localparam int BASE_W = ADDR_W - OFF_W;

  logic [BASE_W-1:0] base_d;
  logic [OFF_W-1:0]  off_d;

  always_comb begin
    base_d = base_q;
    off_d  = off_q;
    if (load_en) begin
      base_d = load_addr[ADDR_W-1:OFF_W];
      off_d  = load_addr[OFF_W-1:0];
    end else if (step_en) begin
      off_d = off_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      off_q  <= '0;
    end else if (load_en || step_en) begin
      base_q <= base_d;
      off_q  <= off_d;
    end
  end

  assert_step_wraps_in_page_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_en) |=> (off_q == OFF_W'($past(off_q) + 1'b1)) && $stable(base_q));
endmodule

// File: rtl/pgwr_latch.sv
// Page latch: one byte and one valid flag per slot.
module pgwr_latch
  import pgwr_pkg::*;
#(
  parameter int PAGE_BYTES = 8,
  parameter int OFF_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_slot,
  input  byte_t            wr_byte,
  input  logic             clr,
  input  logic [OFF_W-1:0] rd_slot,
  output byte_t            rd_byte,
  output logic             rd_valid,
  output logic             any_valid
);
  logic [PAGE_BYTES-1:0] valid_vec;
  byte_t                 byte_arr [PAGE_BYTES];

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
    logic  hit;
    logic  v_d;
    logic  v_q;
    byte_t b_q;

    assign hit = wr_en && (wr_slot == OFF_W'(g));

    always_comb begin
      v_d = v_q;
      if (clr)      v_d = 1'b0;
      else if (hit) v_d = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) v_q <= 1'b0;
      else        v_q <= v_d;
    end

    always_ff @(posedge clk) begin
      if (hit) b_q <= wr_byte;
    end

    assign valid_vec[g] = v_q;
    assign byte_arr[g]  = b_q;
  end

  assign rd_byte   = byte_arr[rd_slot];
  assign rd_valid  = valid_vec[rd_slot];
  assign any_valid = |valid_vec;

  assert_clear_empties_page_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (valid_vec == '0));
  assert_last_byte_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (byte_arr[$past(wr_slot)] == $past(wr_byte)) && valid_vec[$past(wr_slot)]);
  assert_flags_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !clr) |=> $stable(valid_vec));
endmodule

// File: rtl/pgwr_timer.sv
// Self-timed write interval counter.
module pgwr_timer #(
  parameter int WR_CYCLES = 50000,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             busy_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYCLES - 1);

  logic             busy_d;
  logic [CNT_W-1:0] cnt_d;

  assign done = busy_q && (cnt_q == LAST);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        cnt_d  = '0;
      end
    end else if (done) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start || busy_q) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assert_start_opens_interval_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy_q) |=> busy_q && (cnt_q == '0));
  assert_interval_length_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> ($past(cnt_q) == LAST));
endmodule

// File: rtl/pgwr_commit_top.sv
// Page write buffer with a STOP-triggered, self-timed commit to the array.
module pgwr_commit_top
  import pgwr_pkg::*;
#(
  parameter int ADDR_W     = 8,     // 8: 256 bytes, 7: 128 bytes
  parameter int PAGE_BYTES = 8,
  parameter int WR_CYCLES  = 50000  // must be >= PAGE_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              data_stb,
  input  logic [7:0]        data_in,
  input  logic              stop_pulse,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_waddr,
  output logic [7:0]        mem_wdata
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int BASE_W = ADDR_W - OFF_W;
  localparam int CNT_W  = $clog2(WR_CYCLES + 1);
  localparam logic [CNT_W-1:0] WIN_END = CNT_W'(PAGE_BYTES);

  // Asynchronous assert, synchronous release.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              load_en, step_en, start, done, clr;
  logic [BASE_W-1:0] base;
  logic [OFF_W-1:0]  off;
  logic [CNT_W-1:0]  cnt;
  logic [OFF_W-1:0]  slot;
  byte_t             rd_byte;
  logic              rd_valid, any_valid, in_window;

  assign load_en = addr_load && !busy;
  assign step_en = data_stb && !busy && !addr_load;
  assign start   = stop_pulse && any_valid && !busy;
  assign clr     = load_en || done;

  pgwr_ptr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) ptr_i (
    .clk(clk), .rst_n(rst_int_n), .load_en(load_en), .load_addr(addr_in),
    .step_en(step_en), .base_q(base), .off_q(off)
  );

  pgwr_latch #(.PAGE_BYTES(PAGE_BYTES), .OFF_W(OFF_W)) latch_i (
    .clk(clk), .rst_n(rst_int_n), .wr_en(step_en), .wr_slot(off), .wr_byte(data_in),
    .clr(clr), .rd_slot(slot), .rd_byte(rd_byte), .rd_valid(rd_valid), .any_valid(any_valid)
  );

  pgwr_timer #(.WR_CYCLES(WR_CYCLES), .CNT_W(CNT_W)) timer_i (
    .clk(clk), .rst_n(rst_int_n), .start(start), .busy_q(busy), .cnt_q(cnt), .done(done)
  );

  assign slot      = cnt[OFF_W-1:0];
  assign in_window = (cnt < WIN_END);
  assign mem_we    = busy && in_window && rd_valid;
  assign mem_waddr = {base, slot};
  assign mem_wdata = rd_byte;

  assert_empty_stop_stays_idle_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (stop_pulse && !busy && !any_valid && !data_stb) |=> !busy);
  assert_pointer_frozen_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    busy |=> $stable(base) && $stable(off));
  assert_page_kept_during_commit_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (busy && !done) |=> busy && (cnt == $past(cnt) + 1'b1));
endmodule

// File: tb/pgwr_commit_top_tb_top.sv
module pgwr_commit_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WRC        = 12;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_load = 1'b0;
  logic [7:0] addr_in = '0;
  logic       data_stb = 1'b0;
  logic [7:0] data_in = '0;
  logic       stop_pulse = 1'b0;
  logic       busy, mem_we;
  logic [7:0] mem_waddr, mem_wdata;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  logic [7:0] got_mem [256];
  logic [7:0] exp_mem [256];
  logic [7:0] mbuf [8];
  bit   [7:0] mval;
  int         moff, mbase;
  logic [7:0] cbuf [8];
  bit   [7:0] cval;
  int         cbase;
  int         bcnt = 0;
  int         last_len = 0;

  pgwr_commit_top #(.ADDR_W(8), .PAGE_BYTES(8), .WR_CYCLES(WRC)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .data_stb(data_stb), .data_in(data_in), .stop_pulse(stop_pulse),
    .busy(busy), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    if (mem_we) got_mem[mem_waddr] <= mem_wdata;
    cyc++;
    if (cyc == WATCHDOG) begin
      chk(1'b0, "watchdog", "run did not finish", cyc, 0);
      summary();
      $finish;
    end
  end

  // Write monitor: R4 (no write outside busy), R5 (order/address/data), R6 (no missing write).
  always @(negedge clk) begin
    if (busy === 1'b1) begin
      if (mem_we === 1'b1) begin
        chk(bcnt < 8 && cval[bcnt[2:0]] && int'(mem_waddr) == cbase * 8 + bcnt
            && mem_wdata == cbuf[bcnt[2:0]], "R5", "write addr", int'(mem_waddr), cbase * 8 + bcnt);
      end else if (bcnt < 8 && cval[bcnt[2:0]]) begin
        chk(1'b0, "R6", "missing write in slot", bcnt, 1);
      end
      bcnt++;
    end else begin
      if (mem_we === 1'b1) chk(1'b0, "R4", "write while idle", 1, 0);
      if (bcnt > 0) last_len = bcnt;
      bcnt = 0;
    end
  end

  task automatic load_addr(input int a);
    @(posedge clk); #1 addr_load = 1'b1; addr_in = 8'(a);
    @(posedge clk); #1 addr_load = 1'b0;
    mbase = a / 8; moff = a % 8; mval = '0;
  endtask

  task automatic send(input logic [7:0] d);
    @(posedge clk); #1 data_stb = 1'b1; data_in = d;
    @(posedge clk); #1 data_stb = 1'b0;
    mbuf[moff] = d; mval[moff] = 1'b1; moff = (moff + 1) % 8;
  endtask

  task automatic compare_arrays(input string req);
    int mis = 0;
    int first = -1;
    for (int i = 0; i < 256; i++)
      if (got_mem[i] !== exp_mem[i]) begin mis++; if (first < 0) first = i; end
    chk(mis == 0, req, "array mismatches (first at index in actual)", mis == 0 ? 0 : first, 0);
  endtask

  // STOP, then check the busy interval; poke=1 injects traffic during busy (R8).
  task automatic stop_check(input bit poke);
    bit nv;
    int w;
    for (int k = 0; k < 8; k++) cbuf[k] = mbuf[k];
    cval = mval; cbase = mbase; nv = (mval != 0);
    last_len = 0;
    @(posedge clk); #1 stop_pulse = 1'b1;
    @(posedge clk); #1 stop_pulse = 1'b0;
    @(negedge clk);
    chk(busy == nv, nv ? "R4" : "R7", "busy after STOP", int'(busy), int'(nv));
    if (nv) begin
      if (poke) begin
        @(posedge clk); #1 addr_load = 1'b1; addr_in = 8'h93; data_stb = 1'b1; data_in = 8'hEE;
        @(posedge clk); #1 addr_load = 1'b0;
        @(posedge clk); #1 data_stb = 1'b1; data_in = 8'hDD;
        @(posedge clk); #1 data_stb = 1'b0;
      end
      w = 0;
      while (busy === 1'b1 && w < WRC + 10) begin @(negedge clk); w++; end
      @(negedge clk);
      chk(last_len == WRC, "R4", "busy length", last_len, WRC);
      for (int k = 0; k < 8; k++) if (cval[k]) exp_mem[cbase * 8 + k] = cbuf[k];
      mval = '0;
    end else begin
      repeat (3) @(negedge clk);
      chk(busy == 1'b0, "R7", "busy stays low", int'(busy), 0);
    end
    compare_arrays(nv ? "R6" : "R7");
  endtask

  initial begin
    int seed, n, a;
    for (int i = 0; i < 256; i++) begin got_mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    mval = '0; moff = 0; mbase = 0;
    seed = 32'h5eed_1234;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && mem_we == 1'b0, "R1", "outputs in reset", int'({busy, mem_we}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0 && mem_we == 1'b0, "R1", "outputs after reset", int'({busy, mem_we}), 0);

    // R4/R5: single byte write.
    load_addr(8'h35); send(8'hA5); stop_check(1'b0);
    // R2: eight bytes from mid-page, offset wraps 6,7,0..5 inside the page.
    load_addr(8'h46);
    for (int k = 0; k < 8; k++) send(8'(8'h10 + k));
    stop_check(1'b0);
    // R3: eleven bytes, the first three slots overwritten.
    load_addr(8'h80);
    for (int k = 0; k < 11; k++) send(8'(8'h60 + k));
    stop_check(1'b0);
    // R7: address only.
    load_addr(8'hC0); stop_check(1'b0);
    // R9: new address discards earlier bytes; R6: gaps not written.
    load_addr(8'h10); send(8'h11); send(8'h22);
    load_addr(8'h2B); send(8'h33);
    stop_check(1'b0);
    // R8: traffic during busy ignored; then an empty STOP must not restart.
    load_addr(8'h50); send(8'h01); send(8'h02); send(8'h03);
    stop_check(1'b1);
    stop_check(1'b0);
    // R9: commit emptied the page; a plain STOP after a fresh transaction start.
    send(8'h77); stop_check(1'b0);

    // Random transactions.
    for (int t = 0; t < 40; t++) begin
      a = int'($urandom_range(0, 255));
      load_addr(a);
      n = int'($urandom_range(0, 11));
      for (int k = 0; k < n; k++) begin
        if ($urandom_range(0, 9) == 0) load_addr(int'($urandom_range(0, 255)));
        send(8'($urandom));
      end
      stop_check(t % 7 == 3);
    end

    summary();
    $finish;
  end
endmodule